// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. Software sets it up through a small byte-wide register port: it turns the converter on, clears a power gate, chooses one of four single-ended channels and starts a conversion. It can also let the converter restart by itself, or start on the rising edge of one of two trigger inputs. The block drives the analog input selector and the sample-and-hold control. It presents an 8-bit trial code to the external DAC and reads back a single comparator bit that reports whether the held input is at or above the trial level. When a conversion finishes, the result goes to a readable data register, a completion flag is set and an interrupt may be raised.

Conversion time is counted in conversion-clock ticks. One tick is `CLK_DIV` system clocks. The held input is sampled for `SAMPLE_TICKS` ticks and then each result bit takes one tick, from the most significant bit down. One more system clock then stores the result. The analog parts are not in this block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, every register reads 0 (control at address 0, channel at address 1, result at address 2), `sampleHold` and `irq` are 0 and `muxSel` is 0.
- R2: A conversion tries bits 7 down to 0, one per tick, with `dacCode` equal to the bits kept so far plus the bit on trial. The bit is kept when `cmpHigh` is 1, so the result is the largest code whose level is at or below the input.
- R3: With `CLK_DIV`=4 and `SAMPLE_TICKS`=2, the busy bit (control bit 1) reads 1 for exactly 41 clocks after an accepted start, and `sampleHold` is 1 for 40 of them: the 2 sample ticks and the 8 trial ticks.
- R4: The channel field (address 1, bits 1:0) reaches `muxSel` only while the enable bit (control bit 0) is 1. While the block is disabled, `muxSel` keeps its old value.
- R5: While the power gate bit (control bit 6) is 1, start requests are ignored and no conversion runs.
- R6: Writing the enable bit to 0 during a conversion aborts it. Busy and `sampleHold` drop to 0.
- R7: With free-run (control bit 2) set, a new conversion begins as soon as the previous one completes. Busy stays 1 and the result register updates after each conversion.
- R8: Writing 1 to the start bit (control bit 1) while a conversion is running has no effect on it. Busy clears when the conversion completes.
- R9: The completion flag (control bit 4) is set when a conversion completes. `irq` is 1 while both the flag and interrupt enable (control bit 5) are 1. Writing 1 to bit 4 clears the flag.
- R10: With auto-trigger (control bit 3) set, a rising edge on `trigIn[sel]` starts a conversion, where sel is control bit 7. A level held high does not restart the converter, the other input is ignored, and no edge starts a conversion while auto-trigger is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 channel, 2 result) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| trigIn | input | 2 | External trigger sources |
| cmpHigh | input | 1 | Comparator: held input is at or above the trial level |
| dacCode | output | 8 | Trial code for the DAC |
| muxSel | output | 2 | Analog input selector |
| sampleHold | output | 1 | Sample-and-hold control, 1 while the input is held |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
A wrong bit decision shows at the result register as soon as the busy bit drops, because every channel is driven with a different level and the expected code is computed from that level. A miscounted prescaler or sample counter changes the measured busy and hold lengths within one conversion. A bad channel latch shows on `muxSel` within two clocks of the register write. Edge-detection and gating faults show at the busy bit one clock after the trigger or start write.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W  = 8;
  localparam int REG_W  = 8;
  localparam int CHAN_W = 2;
  localparam int TRIG_N = 2;
  localparam int TSEL_W = (TRIG_N > 1) ? $clog2(TRIG_N) : 1;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CHAN = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTL_EN    = 0;
  localparam int CTL_START = 1;
  localparam int CTL_FREE  = 2;
  localparam int CTL_ATRIG = 3;
  localparam int CTL_FLAG  = 4;
  localparam int CTL_IE    = 5;
  localparam int CTL_GATE  = 6;
  localparam int CTL_TSEL  = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONVERT,
    ST_DONE
  } convState_t;

  typedef struct packed {
    logic load;
    logic decide;
    logic commit;
  } sarStrobe_t;
endpackage

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strobe,
  input  logic             cmpHigh,
  output logic [RES_W-1:0] dacCode,
  output logic [RES_W-1:0] result
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] sarReg;
  logic [RES_W-1:0] trialMask;

  assign dacCode = sarReg | trialMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg    <= '0;
      trialMask <= '0;
      result    <= '0;
    end else begin
      if (strobe.load) begin
        sarReg    <= '0;
        trialMask <= TOP_BIT;
      end else if (strobe.decide) begin
        if (cmpHigh) sarReg <= sarReg | trialMask;
        trialMask <= trialMask >> 1;
      end
      if (strobe.commit) result <= sarReg;
    end
  end

  AST_MASK_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide |=> (trialMask == ($past(trialMask) >> 1))); // R2
  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trialMask)); // R2
  AST_COMMIT_ALL_BITS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (trialMask == '0)); // R2
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int SAMPLE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [TRIG_N-1:0] trigIn,
  output logic [REG_W-1:0]  ctrlRd,
  output logic [REG_W-1:0]  chanRd,
  output logic [CHAN_W-1:0] muxSel,
  output logic              sampleHold,
  output logic              irq,
  output sarStrobe_t        strobe
);
  localparam int PRE_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int SMP_W = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
  localparam int BIT_W = $clog2(RES_W);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_DIV - 1);
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLE_TICKS - 1);
  localparam logic [BIT_W-1:0] BIT_TOP  = BIT_W'(RES_W - 1);

  logic enReg, freeReg, atrigReg, flagReg, ieReg, gateReg;
  logic [TSEL_W-1:0] trigSel;
  logic [CHAN_W-1:0] chanReg, muxReg;
  logic [TRIG_N-1:0] trigPrev, trigRise;
  convState_t state;
  logic [PRE_W-1:0] preCnt;
  logic [SMP_W-1:0] smpCnt;
  logic [BIT_W-1:0] bitCnt;

  logic ctrlWr, chanWr, runOk, tick, startReq, launch, restart;

  assign ctrlWr   = regWrEn && (regAddr == ADDR_CTRL);
  assign chanWr   = regWrEn && (regAddr == ADDR_CHAN);
  assign runOk    = enReg && !gateReg;
  assign tick     = (preCnt == PRE_LAST);
  assign trigRise = trigIn & ~trigPrev;
  assign startReq = (ctrlWr && regWrData[CTL_START]) || (atrigReg && trigRise[trigSel]);
  assign launch   = (state == ST_IDLE) && runOk && startReq;
  assign restart  = (state == ST_DONE) && runOk && freeReg;

  assign strobe.load   = launch || restart;
  assign strobe.decide = (state == ST_CONVERT) && tick;
  assign strobe.commit = (state == ST_DONE);

  // Register bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      freeReg  <= 1'b0;
      atrigReg <= 1'b0;
      flagReg  <= 1'b0;
      ieReg    <= 1'b0;
      gateReg  <= 1'b0;
      trigSel  <= '0;
      chanReg  <= '0;
      muxReg   <= '0;
      trigPrev <= '0;
    end else begin
      if (ctrlWr) begin
        enReg    <= regWrData[CTL_EN];
        freeReg  <= regWrData[CTL_FREE];
        atrigReg <= regWrData[CTL_ATRIG];
        ieReg    <= regWrData[CTL_IE];
        gateReg  <= regWrData[CTL_GATE];
        trigSel  <= TSEL_W'(regWrData[CTL_TSEL]);
      end
      if (chanWr) chanReg <= regWrData[CHAN_W-1:0];
      if (enReg) muxReg <= chanReg;
      trigPrev <= trigIn;
      if (state == ST_DONE) flagReg <= 1'b1;
      else if (ctrlWr && regWrData[CTL_FLAG]) flagReg <= 1'b0;
    end
  end

  // Conversion sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      preCnt <= '0;
      smpCnt <= '0;
      bitCnt <= '0;
    end else if (!runOk) begin
      state  <= ST_IDLE;
      preCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            state  <= ST_SAMPLE;
            preCnt <= '0;
            smpCnt <= '0;
          end
        end
        ST_SAMPLE: begin
          preCnt <= tick ? '0 : preCnt + 1'b1;
          if (tick) begin
            if (smpCnt == SMP_LAST) begin
              state  <= ST_CONVERT;
              bitCnt <= BIT_TOP;
            end else begin
              smpCnt <= smpCnt + 1'b1;
            end
          end
        end
        ST_CONVERT: begin
          preCnt <= tick ? '0 : preCnt + 1'b1;
          if (tick) begin
            if (bitCnt == '0) state <= ST_DONE;
            else bitCnt <= bitCnt - 1'b1;
          end
        end
        ST_DONE: begin
          preCnt <= '0;
          smpCnt <= '0;
          state  <= freeReg ? ST_SAMPLE : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sampleHold = (state == ST_SAMPLE) || (state == ST_CONVERT);
  assign irq        = flagReg && ieReg;
  assign muxSel     = muxReg;

  always_comb begin
    ctrlRd              = '0;
    ctrlRd[CTL_EN]      = enReg;
    ctrlRd[CTL_START]   = (state != ST_IDLE);
    ctrlRd[CTL_FREE]    = freeReg;
    ctrlRd[CTL_ATRIG]   = atrigReg;
    ctrlRd[CTL_FLAG]    = flagReg;
    ctrlRd[CTL_IE]      = ieReg;
    ctrlRd[CTL_GATE]    = gateReg;
    ctrlRd[CTL_TSEL]    = trigSel[0];
    chanRd              = '0;
    chanRd[CHAN_W-1:0]  = chanReg;
  end

  AST_MUX_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |=> $stable(muxSel)); // R4
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (gateReg && state == ST_IDLE) |=> (state == ST_IDLE)); // R5
  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |=> !sampleHold); // R6
  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagReg) |-> $past(strobe.commit)); // R9
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int SAMPLE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic              cmpHigh,
  output logic [RES_W-1:0]  dacCode,
  output logic [CHAN_W-1:0] muxSel,
  output logic              sampleHold,
  output logic              irq
);
  sarStrobe_t       strobe;
  logic [REG_W-1:0] ctrlRd, chanRd;
  logic [RES_W-1:0] result;

  sar_ctrl #(.CLK_DIV(CLK_DIV), .SAMPLE_TICKS(SAMPLE_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .trigIn(trigIn), .ctrlRd(ctrlRd), .chanRd(chanRd),
    .muxSel(muxSel), .sampleHold(sampleHold), .irq(irq), .strobe(strobe)
  );

  sar_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .result(result)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = ctrlRd;
      ADDR_CHAN: regRdData = chanRd;
      ADDR_DATA: regRdData = REG_W'(result);
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic [1:0] trigIn = 2'b00;
  logic       cmpHigh;
  logic [7:0] dacCode;
  logic [1:0] muxSel;
  logic       sampleHold;
  logic       irq;

  logic [9:0] chVolt [4];
  int errors = 0;
  int checks = 0;

  // vector: {channel, 10-bit input level}; expected code is level / 4
  localparam logic [11:0] VEC [8] = '{
    {2'd0, 10'd0},   {2'd1, 10'd1023}, {2'd2, 10'd512}, {2'd3, 10'd511},
    {2'd0, 10'd341}, {2'd1, 10'd4},    {2'd2, 10'd3},   {2'd3, 10'd682}
  };

  always #5 clk = ~clk;

  // behavioural comparator + DAC + held input
  assign cmpHigh = (chVolt[muxSel] >= {dacCode, 2'b00});

  sar_conv_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .trigIn(trigIn),
    .cmpHigh(cmpHigh), .dacCode(dacCode), .muxSel(muxSel),
    .sampleHold(sampleHold), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
    regAddr = 2'd0;
    #1;
  endtask

  task automatic waitBusy(output int cnt, output int shCnt);
    logic [7:0] r;
    cnt = 0; shCnt = 0;
    readReg(2'd0, r);
    while (r[1] && cnt < 2000) begin
      cnt++;
      if (sampleHold) shCnt++;
      @(negedge clk);
      readReg(2'd0, r);
    end
  endtask

  task automatic waitFlag();
    logic [7:0] r;
    int n = 0;
    readReg(2'd0, r);
    while (!r[4] && n < 2000) begin
      n++;
      @(negedge clk);
      readReg(2'd0, r);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int cnt, sh;
    for (int c = 0; c < 4; c++) chVolt[c] = 10'd100;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(2'd0, r); check("R1 ctrl", r, 0);
    readReg(2'd1, r); check("R1 chan", r, 0);
    readReg(2'd2, r); check("R1 result", r, 0);
    check("R1 sampleHold/irq", {sampleHold, irq}, 0);
    check("R1 muxSel", muxSel, 0);

    regWrite(2'd0, 8'h01);

    // R2 vector table, R3 timing on each
    for (int v = 0; v < 8; v++) begin
      logic [1:0] ch;
      logic [9:0] vin;
      ch = VEC[v][11:10];
      vin = VEC[v][9:0];
      for (int c = 0; c < 4; c++) chVolt[c] = vin ^ 10'h2AA;
      chVolt[ch] = vin;
      regWrite(2'd1, {6'd0, ch});
      repeat (2) @(negedge clk);
      regWrite(2'd0, 8'h03);
      waitBusy(cnt, sh);
      readReg(2'd2, r);
      check("R2 result", r, int'(vin >> 2));
      check("R3 busy length", cnt, 41);
      check("R3 hold length", sh, 40);
    end

    // R8 start during conversion ignored
    regWrite(2'd0, 8'h03);
    repeat (10) @(negedge clk);
    regWrite(2'd0, 8'h03);
    waitBusy(cnt, sh);
    check("R8 remaining busy", cnt, 29);

    // R9 flag, irq, write-one-to-clear
    regWrite(2'd0, 8'h31);
    check("R9 irq cleared", irq, 0);
    regWrite(2'd0, 8'h23);
    waitBusy(cnt, sh);
    check("R9 irq raised", irq, 1);
    readReg(2'd0, r); check("R9 flag set", r[4], 1);
    regWrite(2'd0, 8'h31);
    check("R9 irq after clear", irq, 0);
    readReg(2'd0, r); check("R9 flag after clear", r[4], 0);

    // R4 channel latch only while enabled
    regWrite(2'd1, 8'h01);
    repeat (2) @(negedge clk);
    check("R4 mux enabled", muxSel, 1);
    regWrite(2'd0, 8'h00);
    regWrite(2'd1, 8'h03);
    repeat (3) @(negedge clk);
    check("R4 mux frozen", muxSel, 1);
    regWrite(2'd0, 8'h01);
    repeat (2) @(negedge clk);
    check("R4 mux applied", muxSel, 3);

    // R5 power gate blocks starts
    regWrite(2'd0, 8'h41);
    regWrite(2'd0, 8'h43);
    repeat (2) @(negedge clk);
    readReg(2'd0, r); check("R5 busy gated", r[1], 0);
    check("R5 hold gated", sampleHold, 0);
    regWrite(2'd0, 8'h01);

    // R6 disable aborts
    regWrite(2'd0, 8'h03);
    repeat (15) @(negedge clk);
    regWrite(2'd0, 8'h00);
    @(negedge clk);
    readReg(2'd0, r); check("R6 busy aborted", r[1], 0);
    check("R6 hold aborted", sampleHold, 0);

    // R7 free-running
    regWrite(2'd0, 8'h11);
    chVolt[3] = 10'd400;
    regWrite(2'd0, 8'h07);
    waitFlag();
    readReg(2'd2, r); check("R7 first result", r, 100);
    chVolt[3] = 10'd800;
    regWrite(2'd0, 8'h15);
    waitFlag();
    readReg(2'd2, r); check("R7 restarted result", r, 200);
    readReg(2'd0, r); check("R7 still busy", r[1], 1);
    regWrite(2'd0, 8'h01);
    waitBusy(cnt, sh);

    // R10 auto-trigger on rising edge of the selected source
    regWrite(2'd0, 8'h19);
    trigIn = 2'b01;
    @(negedge clk);
    readReg(2'd0, r); check("R10 trigger starts", r[1], 1);
    waitBusy(cnt, sh);
    repeat (30) @(negedge clk);
    readReg(2'd0, r); check("R10 level no restart", r[1], 0);
    trigIn = 2'b00;
    @(negedge clk);
    trigIn = 2'b10;
    repeat (3) @(negedge clk);
    readReg(2'd0, r); check("R10 other source ignored", r[1], 0);
    trigIn = 2'b00;
    regWrite(2'd0, 8'h01);
    trigIn = 2'b01;
    repeat (3) @(negedge clk);
    readReg(2'd0, r); check("R10 auto-trigger off", r[1], 0);
    trigIn = 2'b00;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule